// File: doc/BRIEF.md
# Flash Erase Status Flag Generator

This block builds the status byte that a NOR-style flash returns on every read while an internal program or erase is running. A command decoder outside the block selects the operating mode, marks each status read with a one-cycle strobe, and says whether the read address lies in the sector being erased or suspended. The block keeps two toggle bits, a data-polling bit, a timeout lockout flag and the acceptance window that follows a sector erase command. It drives these onto the status byte. In idle mode it passes array data through unchanged.

The acceptance window opens on the first sector erase command. It restarts on every further erase command that arrives while it is still open. When it closes, the internal erase counts as begun and later erase commands are refused. A timeout input latches a failure flag. This flag keeps the block reporting status, with the main toggle bit still running, until a clear command or reset arrives.

Top module: `flash_status_gen`

## Requirements
- R1: After a synchronous active-low reset the lockout flag and erase-begun state are clear. In idle mode (code 0) the status byte then equals the array data input.
- R2: In idle mode with no lockout, the status byte follows `array_data_i` bit for bit, combinationally.
- R3: Bit 6 is held in a register and inverts after each status read in program (code 1), sector erase (code 2) and erase-suspend-program (code 4) modes. It holds its value in erase-suspend-read mode (code 3).
- R4: Bit 2 inverts after each read flagged in-sector in erase or erase-suspend-read mode. It holds on in-sector reads in erase-suspend-program mode. It reads 1 for any read not flagged in-sector and in program mode.
- R5: Bit 7 is the complement of `prog_bit_i` in program and erase-suspend-program modes. It is 0 in erase and erase-suspend-read modes.
- R6: In erase mode, bit 3 reads 0 from the first erase command until WIN_CYC clock edges after the last accepted command, and 1 from then on. It stays 1 through both suspend modes and clears on return to idle or program.
- R7: An erase command in erase mode while bit 3 is 0 restarts the full window. One that arrives after bit 3 has gone to 1 is ignored.
- R8: A timeout pulse in program, erase or erase-suspend-program mode sets bit 5. While bit 5 is set, the status byte is reported even in idle mode, and bit 6 keeps inverting on every read.
- R9: A clear-lockout pulse resets bit 5. Idle-mode pass-through then resumes.
- R10: Whenever status is reported, bits 4, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_stb_i | input | 1 | One-cycle strobe marking a status read |
| in_erase_sector_i | input | 1 | Read address lies in the erasing or suspended sector |
| timeout_i | input | 1 | Internal pulse-count limit exceeded |
| prog_bit_i | input | 1 | Bit 7 of the data being programmed |
| erase_cmd_i | input | 1 | One-cycle sector erase command |
| clr_lock_i | input | 1 | Clears the timeout lockout |
| array_data_i | input | 8 | Array data for idle reads |
| status_o | output | 8 | Status byte, or array data in idle |

## Verification
The bench sweeps every busy mode against both sector flags and both data values over several reads. This catches a bit 6 that runs in suspend-read, or a bit 2 that runs on out-of-sector reads or in suspend-program mode. It samples bit 3 one edge before and one edge at the window's end, both after a single command and after a restart. A window that does not reload, or that closes one cycle early or late, shows up as a wrong bit 3 value at one of those samples. It also sends an erase command after the window has closed, which a design that reopens the window would show as bit 3 dropping back to 0. Last, it checks that a lockout masks idle pass-through and keeps bit 6 running, and that the clear command alone restores pass-through.

// File: rtl/fsg_pkg.sv
// Shared types for the flash status generator.
package fsg_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE = 3'd0,
        MODE_PROG = 3'd1,
        MODE_ERASE = 3'd2,
        MODE_SRD = 3'd3,
        MODE_SPRG = 3'd4
    } fsg_mode_e;
endpackage

// File: rtl/fsg_toggle.sv
// Toggle flag: a single register that inverts on each flip request.
// Assumes flip_i is a single-cycle qualified read strobe.
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic q_o
);
    // Invert on every qualified read; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (flip_i) q_o <= ~q_o;
    end
endmodule

// File: rtl/fsg_lockout.sv
// Timeout lockout flag: set by a qualified timeout, cleared by command.
// Assumes clear has priority over set when both arrive together.
module fsg_lockout (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the failure state until an explicit clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end
endmodule

// File: rtl/fsg_erase_window.sv
// Sector erase acceptance window. A command while the erase has not yet
// begun loads the full window. The erase begins when the count runs out.
// Assumes WIN_CYC >= 2 and that keep_i is low outside erase-related modes.
module fsg_erase_window #(
    parameter int WIN_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_erase_i,
    input  logic keep_i,
    input  logic cmd_i,
    output logic begun_o
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          accept;

    // Commands are taken only in erase mode before the erase has begun.
    always_comb accept = cmd_i && in_erase_i && !begun_o;

    // Load or count down the window; mark the erase begun on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !keep_i) begin
            cnt_q   <= '0;
            begun_o <= 1'b0;
        end else if (accept) begin
            cnt_q <= CW'(WIN_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
// Status byte generator for a flash running embedded program or erase.
// Builds the polling, toggle, timeout and window bits from the mode and
// read strobes; passes array data in idle without lockout.
// Assumes mode_i holds one of the fsg_mode_e codes and strobes are one cycle.
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int WIN_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       rd_stb_i,
    input  logic       in_erase_sector_i,
    input  logic       timeout_i,
    input  logic       prog_bit_i,
    input  logic       erase_cmd_i,
    input  logic       clr_lock_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] status_o
);
    logic is_prog, is_erase, is_srd, is_sprg, is_run;
    logic lock_q, t6_q, t2_q, begun;

    // Decode the operating mode.
    always_comb begin
        is_prog  = (mode_i == MODE_PROG);
        is_erase = (mode_i == MODE_ERASE);
        is_srd   = (mode_i == MODE_SRD);
        is_sprg  = (mode_i == MODE_SPRG);
        is_run   = is_prog || is_erase || is_sprg;
    end

    fsg_lockout u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (timeout_i && is_run),
        .clr_i (clr_lock_i),
        .q_o   (lock_q)
    );

    fsg_toggle u_tog6 (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip_i (rd_stb_i && (is_run || lock_q)),
        .q_o    (t6_q)
    );

    fsg_toggle u_tog2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip_i (rd_stb_i && in_erase_sector_i && (is_erase || is_srd)),
        .q_o    (t2_q)
    );

    fsg_erase_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_erase_i (is_erase),
        .keep_i     (is_erase || is_srd || is_sprg),
        .cmd_i      (erase_cmd_i),
        .begun_o    (begun)
    );

    // Assemble the status byte, or pass array data when idle and unlocked.
    always_comb begin
        if (mode_i == MODE_IDLE && !lock_q) begin
            status_o = array_data_i;
        end else begin
            status_o    = 8'h00;
            status_o[7] = (is_prog || is_sprg) ? ~prog_bit_i : 1'b0;
            status_o[6] = t6_q;
            status_o[5] = lock_q;
            status_o[3] = begun;
            status_o[2] = ((is_erase || is_srd || is_sprg) && in_erase_sector_i)
                          ? t2_q : 1'b1;
        end
    end
endmodule

// File: rtl/fsg_checker.sv
// Property checker for flash_status_gen, attached by bind.
// Assumes the default window is at least two cycles long.
module fsg_checker
    import fsg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       rd_stb_i,
    input logic       timeout_i,
    input logic       erase_cmd_i,
    input logic       clr_lock_i,
    input logic [7:0] array_data_i,
    input logic [7:0] status_o,
    input logic       lock_q
);
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IDLE && !lock_q) |-> status_o == array_data_i);

    assert_b6_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && mode_i == MODE_PROG)
        |=> (mode_i != MODE_PROG || status_o[6] != $past(status_o[6])));

    assert_b6_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && mode_i == MODE_SRD && !lock_q)
        |=> (mode_i != MODE_SRD || lock_q || $stable(status_o[6])));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_cmd_i && mode_i == MODE_ERASE && !status_o[3])
        |=> (mode_i != MODE_ERASE || !status_o[3]));

    assert_lock_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && mode_i == MODE_PROG && !clr_lock_i) |=> status_o[5]);

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !clr_lock_i) |=> lock_q);

    assert_lock_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lock_i |=> !lock_q);

    assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_IDLE || lock_q) |-> (status_o[4] == 1'b0 && status_o[1:0] == 2'b00));
endmodule

bind flash_status_gen fsg_checker u_fsg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .rd_stb_i     (rd_stb_i),
    .timeout_i    (timeout_i),
    .erase_cmd_i  (erase_cmd_i),
    .clr_lock_i   (clr_lock_i),
    .array_data_i (array_data_i),
    .status_o     (status_o),
    .lock_q       (lock_q)
);

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;
    import fsg_pkg::*;
    localparam int W = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       rd = 1'b0, sect = 1'b0, tmo = 1'b0, pbit = 1'b0, cmd = 1'b0, clr = 1'b0;
    logic [7:0] arr = 8'h00;
    logic [7:0] st;
    int         n_vec = 0, n_bad = 0;

    always #2 clk = ~clk;

    flash_status_gen #(.WIN_CYC(W)) u_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_stb_i(rd),
        .in_erase_sector_i(sect), .timeout_i(tmo), .prog_bit_i(pbit),
        .erase_cmd_i(cmd), .clr_lock_i(clr), .array_data_i(arr), .status_o(st)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode = 3'd0; rd = 0; sect = 0; tmo = 0; pbit = 0; cmd = 0; clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_rd();
        rd = 1'b1; @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulse_cmd();
        cmd = 1'b1; @(negedge clk); cmd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic e6, e2, b7, b2;
        // R1: reset state
        do_reset();
        arr = 8'hA5; #1 chk("R1 idle after reset", st, 8'hA5);
        mode = MODE_ERASE; #1 chk("R1 bit3/bit5 clear", st & 8'h28, 8'h00);
        mode = MODE_IDLE;

        // R2: exhaustive idle pass-through
        for (int v = 0; v < 256; v++) begin
            arr = 8'(v); #1 chk("R2 pass-through", st, 8'(v));
        end

        // R3 R4 R5 R10: sweep busy modes x sector flag x data bit
        for (int m = 1; m < 5; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    do_reset();
                    mode = 3'(m); sect = 1'(s); pbit = 1'(p);
                    e6 = 0; e2 = 0;
                    for (int r = 0; r < 4; r++) begin
                        #1;
                        b7 = (m == 1 || m == 4) ? ~pbit : 1'b0;
                        b2 = ((m == 2 || m == 3 || m == 4) && s == 1) ? e2 : 1'b1;
                        chk("R5 bit7", {7'd0, st[7]}, {7'd0, b7});
                        chk("R3 bit6", {7'd0, st[6]}, {7'd0, e6});
                        chk("R4 bit2", {7'd0, st[2]}, {7'd0, b2});
                        chk("R10 zero bits", st & 8'h3B, 8'h00);
                        pulse_rd();
                        if (m != 3) e6 = ~e6;
                        if (s == 1 && (m == 2 || m == 3)) e2 = ~e2;
                    end
                end
            end
        end

        // R6: window expiry timing after a single command
        do_reset();
        mode = MODE_ERASE; #1 chk("R6 bit3 before cmd", {7'd0, st[3]}, 8'd0);
        pulse_cmd();
        repeat (W - 1) @(negedge clk);
        #1 chk("R6 bit3 last open cycle", {7'd0, st[3]}, 8'd0);
        @(negedge clk); #1 chk("R6 bit3 after window", {7'd0, st[3]}, 8'd1);
        mode = MODE_SRD; #1 chk("R6 bit3 kept in suspend", {7'd0, st[3]}, 8'd1);
        mode = MODE_IDLE; @(negedge clk);
        mode = MODE_ERASE; #1 chk("R6 bit3 cleared via idle", {7'd0, st[3]}, 8'd0);

        // R7: restart within window, ignore after expiry
        do_reset();
        mode = MODE_ERASE;
        pulse_cmd();
        repeat (5) @(negedge clk);
        pulse_cmd();
        repeat (W - 1) @(negedge clk);
        #1 chk("R7 restarted window open", {7'd0, st[3]}, 8'd0);
        @(negedge clk); #1 chk("R7 restarted window closed", {7'd0, st[3]}, 8'd1);
        pulse_cmd();
        for (int k = 0; k < 3; k++) begin
            #1 chk("R7 late cmd ignored", {7'd0, st[3]}, 8'd1);
            @(negedge clk);
        end

        // R8 R9: timeout lockout
        do_reset();
        mode = MODE_PROG; arr = 8'h00;
        tmo = 1'b1; @(negedge clk); tmo = 1'b0;
        #1 chk("R8 bit5 set", {7'd0, st[5]}, 8'd1);
        pulse_rd(); #1 chk("R8 bit6 runs", {7'd0, st[6]}, 8'd1);
        mode = MODE_IDLE; #1 chk("R8 idle masked", st, 8'h64);
        pulse_rd(); #1 chk("R8 bit6 runs in idle", st, 8'h24);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        arr = 8'h5A; #1 chk("R9 pass-through restored", st, 8'h5A);
        mode = MODE_ERASE;
        tmo = 1'b1; @(negedge clk); tmo = 1'b0;
        do_reset();
        arr = 8'hC3; #1 chk("R1 reset clears lockout", st, 8'hC3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule